// File: doc/BRIEF.md
# Two-Bit Mealy Sequence Machine

This block is a small clocked state machine that holds two state bits, called A and B, and watches one serial input bit. On every rising clock edge it loads a new state taken from fixed next-state equations of the present state and the input. Its single output is a Mealy output: it is formed with no register from the present state and the current input, so it can change between clock edges when the input changes.

The four states have their own names. `ST_REST` is A=0, B=0. `ST_RISE` is A=0, B=1. `ST_HOLD` is A=1, B=0. `ST_PEAK` is A=1, B=1. A is the upper bit of the state code and B is the lower bit. Only four transitions occur. Any state moves to `ST_REST` when x=0 (the clear transition). When x=1, `ST_REST` moves to `ST_RISE` (the start transition), `ST_RISE` moves to `ST_PEAK` (the climb transition), and both `ST_HOLD` and `ST_PEAK` move to `ST_HOLD` (the settle transition). The design computes the next state as A' = (A&x)|(B&x) and B' = ~A&x. It drives y = (A|B)&~x.

The state bits appear on ports so that a system or a bench can follow the sequence. A synchronous, active-high reset returns the machine to `ST_REST`.

Top module: `mealy2_fsm`

## Requirements
- R1: While `rst` is 1 at a rising edge of `clk`, the state after that edge is `ST_REST` (a_q=0, b_q=0), whatever x is.
- R2: With rst=0 and x=0 at a rising edge, the next state is `ST_REST` from every present state.
- R3: With rst=0 and x=1 at a rising edge, `ST_REST` (00) moves to `ST_RISE` (01).
- R4: With rst=0 and x=1 at a rising edge, `ST_RISE` (01) moves to `ST_PEAK` (11).
- R5: With rst=0 and x=1 at a rising edge, `ST_HOLD` (10) and `ST_PEAK` (11) both move to `ST_HOLD` (10).
- R6: While x=0, y is 1 in `ST_RISE`, `ST_HOLD` and `ST_PEAK`, and y is 0 in `ST_REST`.
- R7: While x=1, y is 0 in every state.
- R8: a_q and b_q change only at rising clock edges. y follows a change of x between edges, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The state loads on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| x | input | 1 | Serial input bit. |
| a_q | output | 1 | State bit A, the upper bit of the state code. |
| b_q | output | 1 | State bit B, the lower bit of the state code. |
| y | output | 1 | Mealy output, combinational from the state and x. |

## Verification
The block has no parameters, so the bench builds it exactly as it is. The bench first drives every one of the eight state and input pairs on purpose. It reaches `ST_RISE`, `ST_PEAK` and `ST_HOLD` through short runs of ones after a reset, and then compares both the output and the next state against a table model in the bench. Next it drives a long run of seeded random input with occasional resets, which exercises the transitions in many orders. It also toggles x inside a single clock period to show that y follows x while the state bits stay where they are.

// File: rtl/mealy2_pkg.sv
package mealy2_pkg;

    localparam int unsigned STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_REST = 2'b00,
        ST_RISE = 2'b01,
        ST_HOLD = 2'b10,
        ST_PEAK = 2'b11
    } mealy2_state_e;

endpackage

// File: rtl/mealy2_next.sv
module mealy2_next
    import mealy2_pkg::*;
(
    input  mealy2_state_e cur_st,
    input  logic          x,
    output mealy2_state_e nxt_st
);

    always_comb begin
        nxt_st = ST_REST;
        unique case (cur_st)
            ST_REST: nxt_st = x ? ST_RISE : ST_REST;
            ST_RISE: nxt_st = x ? ST_PEAK : ST_REST;
            ST_HOLD: nxt_st = x ? ST_HOLD : ST_REST;
            ST_PEAK: nxt_st = x ? ST_HOLD : ST_REST;
            default: nxt_st = ST_REST;
        endcase
    end

endmodule

// File: rtl/mealy2_out.sv
module mealy2_out
    import mealy2_pkg::*;
(
    input  mealy2_state_e cur_st,
    input  logic          x,
    output logic          y
);

    always_comb begin
        y = 1'b0;
        unique case (cur_st)
            ST_REST: y = 1'b0;
            ST_RISE: y = ~x;
            ST_HOLD: y = ~x;
            ST_PEAK: y = ~x;
            default: y = 1'b0;
        endcase
    end

endmodule

// File: rtl/mealy2_fsm.sv
module mealy2_fsm
    import mealy2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output logic a_q,
    output logic b_q,
    output logic y
);

    mealy2_state_e state_q;
    mealy2_state_e state_d;

    mealy2_next u_next (
        .cur_st (state_q),
        .x      (x),
        .nxt_st (state_d)
    );

    mealy2_out u_out (
        .cur_st (state_q),
        .x      (x),
        .y      (y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_REST;
        end else begin
            state_q <= state_d;
        end
    end

    assign a_q = state_q[1];
    assign b_q = state_q[0];

    assert_reset_rest_R1: assert property (@(posedge clk)
        rst |=> (a_q == 1'b0 && b_q == 1'b0));

    assert_clear_on_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !x |=> (a_q == 1'b0 && b_q == 1'b0));

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (x && !a_q && !b_q) |=> (!a_q && b_q));

    assert_climb_R4: assert property (@(posedge clk) disable iff (rst)
        (x && !a_q && b_q) |=> (a_q && b_q));

    assert_settle_R5: assert property (@(posedge clk) disable iff (rst)
        (x && a_q) |=> (a_q && !b_q));

    assert_out_low_input_R6: assert property (@(posedge clk) disable iff (rst)
        !x |-> (y == (a_q | b_q)));

    assert_out_high_input_R7: assert property (@(posedge clk) disable iff (rst)
        x |-> !y);

endmodule

// File: tb/mealy2_fsm_tb_top.sv
`timescale 1ns/1ps
module mealy2_fsm_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic a_q, b_q, y;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [1:0] mdl = 2'b00;

    always #10 clk = ~clk;

    mealy2_fsm dut_i (
        .clk (clk),
        .rst (rst),
        .x   (x),
        .a_q (a_q),
        .b_q (b_q),
        .y   (y)
    );

    function automatic logic [1:0] exp_next(input logic [1:0] s, input logic xi);
        logic na, nb;
        na = (s[1] & xi) | (s[0] & xi);
        nb = ~s[1] & xi;
        return {na, nb};
    endfunction

    function automatic logic exp_y(input logic [1:0] s, input logic xi);
        return (s[1] | s[0]) & ~xi;
    endfunction

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] want);
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, want);
        end
    endtask

    function automatic string state_req(input logic [1:0] s, input logic xi, input logic r);
        if (r)            return "R1";
        if (!xi)          return "R2";
        if (s == 2'b00)   return "R3";
        if (s == 2'b01)   return "R4";
        return "R5";
    endfunction

    task automatic step(input logic xv, input logic rv);
        logic [1:0] prev;
        @(negedge clk);
        x   = xv;
        rst = rv;
        #2;
        check(xv ? "R7" : "R6", {1'b0, y}, {1'b0, exp_y(mdl, xv)});
        prev = mdl;
        @(posedge clk);
        mdl = rv ? 2'b00 : exp_next(prev, xv);
        #2;
        check(state_req(prev, xv, rv), {a_q, b_q}, mdl);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(1'b1, 1'b1);
        check("R1", {a_q, b_q}, 2'b00);

        for (int s = 0; s < 4; s++) begin
            for (int xv = 0; xv < 2; xv++) begin
                step(1'b0, 1'b1);
                if (s == 1) step(1'b1, 1'b0);
                if (s == 3) begin step(1'b1, 1'b0); step(1'b1, 1'b0); end
                if (s == 2) begin step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); end
                check("R1", {a_q, b_q}, 2'(s));
                step(xv[0], 1'b0);
            end
        end

        // R8: toggle x within one period in ST_PEAK
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        @(negedge clk);
        x = 1'b0;
        #2;
        check("R8", {1'b0, y}, 2'b01);
        check("R8", {a_q, b_q}, 2'b11);
        #3;
        x = 1'b1;
        #2;
        check("R8", {1'b0, y}, 2'b00);
        check("R8", {a_q, b_q}, 2'b11);
        #2;
        x = 1'b0;
        #1;
        check("R8", {1'b0, y}, 2'b01);
        check("R8", {a_q, b_q}, 2'b11);
        @(posedge clk);
        mdl = 2'b00;
        #2;
        check("R2", {a_q, b_q}, 2'b00);

        begin
            int unsigned seed_dummy;
            seed_dummy = $urandom(32'h5EED_1234);
        end
        for (int i = 0; i < 2000; i++) begin
            logic xv, rv;
            xv = ($urandom % 4) != 0;
            rv = ($urandom % 50) == 0;
            step(xv, rv);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule